// File: doc/BRIEF.md
# Return-to-Zero Infrared Pulse Demodulator

This block sits in front of a UART receiver in infrared mode. The line arrives as short return-to-zero pulses, one for each zero bit. The block turns that pulse stream back into an ordinary NRZ serial line. It runs on the system clock. A single-cycle oversampling strobe marks sixteen equal steps per bit. Each detected pulse edge starts a bit timer. The timer holds the NRZ output low for sixteen strobes and then lets it return high.

The pulse edge can be the rising edge of the incoming line or, when the invert control is set, the falling edge. A pulse that arrives while the timer is still running reloads it. Back-to-back zero bits therefore give one continuous low level. The only exception is a possible high blip shorter than one strobe period, and the receiver ignores it because it samples at mid-bit. With demodulation disabled, the synchronized line goes straight to the output. Glitch filtering is assumed to happen upstream.

Top module: `rz_pulse_demod`

## Requirements
- R1: While reset is asserted and after it is released with an idle line, the NRZ output is high and the bit timer is idle.
- R2: With demodulation enabled and invert clear, a rise of the receive line set up before a clock edge drives the output low after exactly the third rising clock edge. The output is still high after the second edge.
- R3: A single pulse holds the output low until the sixteenth oversampling strobe that comes after the pulse edge was taken. That strobe returns the output high.
- R4: The width of a pulse does not matter. A pulse held high for longer than a bit time still gives exactly sixteen strobes of low. Its falling edge starts no new low period when invert is clear.
- R5: A new edge that arrives while the output is low reloads the timer. The low period then ends sixteen strobes after the later edge.
- R6: With pulses spaced exactly sixteen strobes apart, any high gap between the resulting low periods is shorter than one strobe period.
- R7: With invert set (idle line high), a falling edge of the line starts the low period and the rising edge that follows it has no effect.
- R8: With demodulation disabled, the output equals the receive line delayed by two clock edges, whatever the invert setting.
- R9: The timer only advances on strobes. With the strobe held low, the output stays low for as long as the strobe is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| os_tick_i | input | 1 | One-cycle oversampling strobe, sixteen per bit |
| rz_rx_i | input | 1 | Filtered return-to-zero receive line |
| demod_en_i | input | 1 | 1: demodulate; 0: pass the synchronized line through |
| rz_invert_i | input | 1 | 1: falling edge is the pulse edge (idle high) |
| nrz_rx_o | output | 1 | NRZ receive line to the UART |

## Verification
Inputs change on the falling clock edge, and outputs are read a quarter period after the rising edge. The first low sample is due right after the third rising edge following a line change, and the passthrough copy is due after the second rising edge. The length of a low period is due in strobes, not cycles. The scoreboard therefore counts only the rising edges that saw the output low with the strobe high, and it compares that count with the figure the driver queued: 16 for a plain pulse, or the reload spacing plus 16 when the timer is reloaded with the strobe held high every cycle. The blip check measures high runs in cycles against the four-cycle strobe period.

// File: rtl/rzd_pkg.sv
package rzd_pkg;

   // Counter width needed to hold values 0 .. ticks-1
   function automatic int unsigned tick_cnt_width(input int unsigned ticks);
      return (ticks <= 2) ? 1 : $clog2(ticks);
   endfunction

   // Selects which clock edges of the line count as a pulse edge
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } pulse_edge_e;

endpackage

// File: rtl/rzd_edge_sync.sv
module rzd_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic invert_i,
   output logic sync_o,
   output logic edge_o
);
   import rzd_pkg::*;

   logic [STAGES-1:0] stage_q;
   logic              last_q;
   pulse_edge_e       sel;
   logic              pol_now;
   logic              pol_last;

   if (STAGES < 2) begin : g_bad_stages
      $error("rzd_edge_sync: STAGES must be at least 2");
   end

   // Synchronizer chain, one flop per stage
   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[0] <= 1'b0;
            else         stage_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[s] <= 1'b0;
            else         stage_q[s] <= stage_q[s-1];
         end
      end
   end

   // Previous synchronized value for edge detection
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b0;
      else         last_q <= stage_q[STAGES-1];
   end

   assign sel      = pulse_edge_e'(invert_i);
   assign sync_o   = stage_q[STAGES-1];
   assign pol_now  = (sel == EDGE_FALL) ? ~stage_q[STAGES-1] : stage_q[STAGES-1];
   assign pol_last = (sel == EDGE_FALL) ? ~last_q : last_q;
   assign edge_o   = pol_now & ~pol_last;

endmodule

// File: rtl/rzd_bit_timer.sv
module rzd_bit_timer #(
   parameter int unsigned TICKS_PER_BIT = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic start_i,
   output logic busy_o
);
   import rzd_pkg::*;

   localparam int unsigned CW = tick_cnt_width(TICKS_PER_BIT);
   localparam logic [CW-1:0] RELOAD = CW'(TICKS_PER_BIT - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("rzd_bit_timer: TICKS_PER_BIT must be at least 2");
   end

   // An edge always wins and reloads; otherwise count down on strobes.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= RELOAD;
         busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;

   assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> (cnt_q == '0));

   assert_reload_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (busy_q && cnt_q == RELOAD));

   assert_release_on_last_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && tick_i && cnt_q == '0 && !start_i) |=> !busy_q);

   assert_hold_without_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && !tick_i && !start_i) |=> (busy_q && $stable(cnt_q)));

   assert_busy_needs_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> $past(start_i));

endmodule

// File: rtl/rz_pulse_demod.sv
module rz_pulse_demod #(
   parameter int unsigned TICKS_PER_BIT = 16,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic os_tick_i,
   input  logic rz_rx_i,
   input  logic demod_en_i,
   input  logic rz_invert_i,
   output logic nrz_rx_o
);

   logic line_sync;
   logic pulse_edge;
   logic timer_busy;

   rzd_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (rz_rx_i),
      .invert_i(rz_invert_i),
      .sync_o  (line_sync),
      .edge_o  (pulse_edge)
   );

   rzd_bit_timer #(
      .TICKS_PER_BIT(TICKS_PER_BIT)
   ) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (os_tick_i),
      .start_i(pulse_edge & demod_en_i),
      .busy_o (timer_busy)
   );

   assign nrz_rx_o = demod_en_i ? ~timer_busy : line_sync;

   assert_reset_idle_R1: assert property (@(posedge clk_i)
      (!rst_ni && demod_en_i) |-> nrz_rx_o);

   assert_passthru_timer_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!demod_en_i && !timer_busy) |=> (!timer_busy || demod_en_i));

endmodule

// File: tb/rz_pulse_demod_tb.sv
module rz_pulse_demod_tb_top;

   localparam int CLK_P = 10;
   localparam int TPB   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic rz = 1'b0;
   logic en = 1'b1;
   logic inv = 1'b0;
   logic nrz;

   int checks = 0;
   int errors = 0;
   int tick_div = 4;
   int tdc = 0;
   bit mon_on = 1'b0;
   int exp_q[$];

   rz_pulse_demod #(.TICKS_PER_BIT(TPB), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rz_rx_i(rz),
      .demod_en_i(en), .rz_invert_i(inv), .nrz_rx_o(nrz)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic sample();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Drive one pulse of the given width at the active level, then back to idle
   task automatic pulse(input int width, input logic active);
      @(negedge clk);
      rz = active;
      for (int i = 1; i < width; i++) @(negedge clk);
      @(negedge clk);
      rz = ~active;
   endtask

   // Oversampling strobe generator, driven on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (tick_div == 0) begin
            tick = 1'b0;
            tdc  = 0;
         end else begin
            tick = (tdc == 0);
            tdc  = (tdc + 1 >= tick_div) ? 0 : tdc + 1;
         end
      end
   end

   // Scoreboard monitor: counts strobes taken while the output was low
   initial begin
      bit prev_out = 1'b1;
      bit in_run = 1'b0;
      int run_ticks = 0;
      forever begin
         sample();
         if (!mon_on) begin
            in_run = 1'b0;
            prev_out = nrz;
            continue;
         end
         if (in_run && !prev_out && tick) run_ticks++;
         if (!nrz && prev_out) begin
            in_run = 1'b1;
            run_ticks = 0;
         end else if (nrz && !prev_out && in_run) begin
            in_run = 1'b0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 unexpected low run", run_ticks, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               check(run_ticks == e, "R3/R5 low run length in strobes", run_ticks, e);
            end
         end
         prev_out = nrz;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int lows;
      int hi_run;
      int hi_max;
      // R1: reset state
      idle(3);
      sample();
      check(nrz == 1'b1, "R1 output high in reset", nrz, 1);
      @(negedge clk);
      rst_n = 1'b1;
      idle(4);
      sample();
      check(nrz == 1'b1, "R1 output high after reset", nrz, 1);
      mon_on = 1'b1;

      // R2: latency of three edges; R3: sixteen strobes
      exp_q.push_back(TPB);
      @(negedge clk);
      rz = 1'b1;
      sample();
      check(nrz == 1'b1, "R2 high after first edge", nrz, 1);
      sample();
      check(nrz == 1'b1, "R2 high after second edge", nrz, 1);
      sample();
      check(nrz == 1'b0, "R2 low after third edge", nrz, 0);
      @(negedge clk);
      rz = 1'b0;
      idle(100);

      // R4: long pulse, and its falling edge does nothing
      exp_q.push_back(TPB);
      pulse(100, 1'b1);
      lows = 0;
      for (int i = 0; i < 60; i++) begin
         sample();
         if (!nrz) lows++;
      end
      check(lows == 0, "R4 no low after falling edge", lows, 0);

      // R3 with the strobe every cycle
      tick_div = 1;
      exp_q.push_back(TPB);
      pulse(3, 1'b1);
      idle(40);

      // R5: reload while low; rises five cycles apart
      exp_q.push_back(5 + TPB);
      pulse(2, 1'b1);
      idle(2);
      pulse(2, 1'b1);
      idle(50);

      // R9: strobe absent holds the output low
      tick_div = 0;
      exp_q.push_back(TPB);
      pulse(4, 1'b1);
      idle(100);
      sample();
      check(nrz == 1'b0, "R9 held low without strobes", nrz, 0);
      @(negedge clk);
      tick_div = 1;
      idle(40);
      sample();
      check(nrz == 1'b1, "R9 released once strobes resume", nrz, 1);

      // R7: inverted polarity, idle high line
      mon_on = 1'b0;
      @(negedge clk);
      en = 1'b0;
      inv = 1'b1;
      rz = 1'b1;
      idle(40);
      en = 1'b1;
      tick_div = 4;
      idle(20);
      sample();
      check(nrz == 1'b1, "R7 idle high with inverted line", nrz, 1);
      mon_on = 1'b1;
      exp_q.push_back(TPB);
      pulse(12, 1'b0);
      idle(90);
      sample();
      check(nrz == 1'b1, "R7 rising edge ignored", nrz, 1);

      // R8: passthrough, invert has no effect
      mon_on = 1'b0;
      @(negedge clk);
      en = 1'b0;
      rz = 1'b0;
      idle(10);
      @(negedge clk);
      rz = 1'b1;
      sample();
      check(nrz == 1'b0, "R8 passthrough after one edge", nrz, 0);
      sample();
      check(nrz == 1'b1, "R8 passthrough after two edges", nrz, 1);
      @(negedge clk);
      inv = 1'b0;
      rz = 1'b0;
      sample();
      sample();
      check(nrz == 1'b0, "R8 passthrough follows low, invert ignored", nrz, 0);
      idle(40);
      en = 1'b1;
      idle(40);

      // R6: pulses sixteen strobes apart, blip shorter than a strobe period
      tick_div = 4;
      idle(3);
      fork
         begin
            for (int p = 0; p < 3; p++) begin
               pulse(12, 1'b1);
               idle(64 - 13);
            end
         end
         begin
            while (nrz) sample();
            hi_run = 0;
            hi_max = 0;
            lows = 0;
            for (int i = 0; i < 130; i++) begin
               sample();
               if (nrz) begin
                  hi_run++;
                  if (hi_run > hi_max) hi_max = hi_run;
               end else begin
                  hi_run = 0;
                  lows++;
               end
            end
            check(hi_max < 4, "R6 blip shorter than one strobe period", hi_max, 3);
            check(lows > 120, "R6 low held across back-to-back bits", lows, 121);
         end
      join
      idle(100);
      sample();
      check(nrz == 1'b1, "R6 output back high after pulses", nrz, 1);

      check(exp_q.size() == 0, "R3 all expected low runs seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule